// File: doc/BRIEF.md
# Trigger Acceptance Flow Controller

This block sits between the first-level trigger decision and the readout system. Each cycle it may receive a pass request. It turns that request into an accept pulse only when nothing is holding acceptance off. Three things hold it off:

- a busy line from any of several acquisition crates;
- an internal rate-limit window that opens after every accept;
- an overflow flag that stays up until software acknowledges that the time stamp of the last accept has been read.

A small register port can start a calibration sequence. The sequence first emits a one-cycle calibration pulse, waits a programmable number of ticks and then raises its own accept request, which is gated like any pass. Each accept gets a running event number and is stamped with the free-running tick counter. A synch marker goes out alongside every accept whose event number is a multiple of 256, so downstream counters can be cross-checked. A pass counter runs alongside the event number, and their difference gives the number of suppressed triggers.

Top module: `trig_accept_ctrl`

## Requirements
- R1: After reset all outputs are zero. An accept_o pulse of one cycle follows, one clock later, every clock edge at which pass_i is high and busy_o is low.
- R2: While any bit of crate_busy_i is high, busy_o is high and no pass request is accepted.
- R3: After an accept, no further accept occurs within SELF_BUSY_TICKS cycles. Two accepts are therefore at least SELF_BUSY_TICKS+1 cycles apart. The default is ceil(1 ms / 42 ns) = 23810 ticks.
- R4: After an accept, no further accept occurs until a write to register address 2 (readout acknowledge). An acknowledge written at the same edge as an accept leaves the flag set.
- R5: A write to address 0 makes cal_o high for exactly the following cycle. A write to address 1 loads reg_wdata_i as the calibration delay D, which resets to CAL_DLY_RST. With nothing busy, the calibration accept_o appears exactly D+2 cycles after the cal_o cycle.
- R6: A due calibration accept waits while busy_o is high and is issued in the cycle after busy clears. A start write while a sequence is running is ignored.
- R7: When a calibration accept is due at the same edge as a granted pass request, exactly one accept is issued and the pass counter rises by one.
- R8: synch_o is high together with accept_o exactly when the event number reached by that accept is a multiple of 2^SYNC_LOG2 (256 by default).
- R9: evt_num_o rises by one per accept. pass_total_o rises by one per edge with pass_i high or with a calibration accept. suppressed_o equals pass_total_o minus evt_num_o.
- R10: evt_time_o holds the value of a tick counter at the accepting edge. The counter is 0 at the first edge after reset release and rises by one per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 42 ns trigger tick clock |
| rst | input | 1 | synchronous active-high reset |
| pass_i | input | 1 | level-one pass request, one per high cycle |
| crate_busy_i | input | N_CRATES | busy lines from acquisition crates |
| reg_wr_i | input | 1 | register write strobe |
| reg_addr_i | input | 2 | register address: 0 start calibration, 1 delay, 2 readout ack |
| reg_wdata_i | input | CAL_W | register write data |
| accept_o | output | 1 | gated accept pulse |
| cal_o | output | 1 | calibration pulse |
| synch_o | output | 1 | synch marker, coincident with accept |
| busy_o | output | 1 | combined busy |
| evt_num_o | output | EVT_W | event number of the last accept |
| pass_total_o | output | EVT_W | total pass requests |
| suppressed_o | output | EVT_W | passes that produced no accept |
| evt_time_o | output | TIME_W | time stamp of the last accept |

## Verification
The calibration sequence and an external pass request can both ask for an accept at the same edge. The bench provokes this by raising pass_i in the exact cycle the calibration delay ends. It then expects a single accept_o pulse, one increment of both counters, and no second accept afterwards. The synch marker always coincides with an accept. A long run of accepts checks that synch_o is high on the 256th accept and low on every other one.

// File: rtl/trig_accept_pkg.sv
package trig_accept_pkg;

    localparam longint TICK_PS          = 42_000;
    localparam longint RATE_WINDOW_PS   = 1_000_000_000;

    function automatic int ceil_div(input longint num, input longint den);
        return int'((num + den - 1) / den);
    endfunction

    localparam int DEFAULT_SELF_BUSY = ceil_div(RATE_WINDOW_PS, TICK_PS);

    typedef enum logic [1:0] {
        RA_CAL_GO  = 2'd0,
        RA_CAL_DLY = 2'd1,
        RA_RO_ACK  = 2'd2,
        RA_SPARE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic cal_go;
        logic cal_dly;
        logic ro_ack;
    } reg_cmd_t;

    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_WAIT = 2'd1,
        CAL_DUE  = 2'd2
    } cal_state_e;

    typedef struct packed {
        logic grant;
        logic from_pass;
        logic from_cal;
    } accept_req_t;

    function automatic reg_cmd_t decode_cmd(input logic wr, input logic [1:0] addr);
        reg_cmd_t c;
        c.cal_go  = wr && (addr == RA_CAL_GO);
        c.cal_dly = wr && (addr == RA_CAL_DLY);
        c.ro_ack  = wr && (addr == RA_RO_ACK);
        return c;
    endfunction

endpackage

// File: rtl/trig_busy_unit.sv
module trig_busy_unit #(
    parameter int SELF_BUSY_TICKS = 23810,
    localparam int SB_W = $clog2(SELF_BUSY_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic ro_ack,
    output logic self_busy,
    output logic ovf_busy
);

    logic [SB_W-1:0] sb_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sb_cnt <= '0;
        end else if (fire) begin
            sb_cnt <= SB_W'(SELF_BUSY_TICKS);
        end else if (sb_cnt != '0) begin
            sb_cnt <= sb_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_busy <= 1'b0;
        end else if (fire) begin
            ovf_busy <= 1'b1;
        end else if (ro_ack) begin
            ovf_busy <= 1'b0;
        end
    end

    assign self_busy = (sb_cnt != '0);

endmodule

// File: rtl/trig_cal_seq.sv
module trig_cal_seq
    import trig_accept_pkg::*;
#(
    parameter int CAL_W       = 16,
    parameter int CAL_DLY_RST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             dly_wr,
    input  logic [CAL_W-1:0] wdata,
    input  logic             grant,
    output logic             cal_pulse,
    output logic             cal_due
);

    cal_state_e       state;
    logic [CAL_W-1:0] dly_reg;
    logic [CAL_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_reg <= CAL_W'(CAL_DLY_RST);
        end else if (dly_wr) begin
            dly_reg <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CAL_IDLE;
            cnt       <= '0;
            cal_pulse <= 1'b0;
        end else begin
            cal_pulse <= 1'b0;
            unique case (state)
                CAL_IDLE: begin
                    if (go) begin
                        state     <= CAL_WAIT;
                        cnt       <= dly_reg;
                        cal_pulse <= 1'b1;
                    end
                end
                CAL_WAIT: begin
                    if (cnt == '0) begin
                        state <= CAL_DUE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                CAL_DUE: begin
                    if (grant) begin
                        state <= CAL_IDLE;
                    end
                end
                default: state <= CAL_IDLE;
            endcase
        end
    end

    assign cal_due = (state == CAL_DUE);

endmodule

// File: rtl/trig_event_book.sv
module trig_event_book
    import trig_accept_pkg::*;
#(
    parameter int EVT_W     = 24,
    parameter int TIME_W    = 32,
    parameter int SYNC_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  accept_req_t       req,
    output logic              accept,
    output logic              synch,
    output logic [EVT_W-1:0]  evt_num,
    output logic [EVT_W-1:0]  pass_total,
    output logic [TIME_W-1:0] evt_time
);

    logic [TIME_W-1:0] time_ctr;
    logic [EVT_W-1:0]  evt_next;
    logic              count_pass;

    assign evt_next   = evt_num + 1'b1;
    assign count_pass = req.from_pass || (req.from_cal && req.grant);

    always_ff @(posedge clk) begin
        if (rst) begin
            time_ctr <= '0;
        end else begin
            time_ctr <= time_ctr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            accept   <= 1'b0;
            synch    <= 1'b0;
            evt_num  <= '0;
            evt_time <= '0;
        end else begin
            accept <= req.grant;
            synch  <= req.grant && (evt_next[SYNC_LOG2-1:0] == '0);
            if (req.grant) begin
                evt_num  <= evt_next;
                evt_time <= time_ctr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_total <= '0;
        end else if (count_pass) begin
            pass_total <= pass_total + 1'b1;
        end
    end

endmodule

// File: rtl/trig_accept_ctrl.sv
module trig_accept_ctrl
    import trig_accept_pkg::*;
#(
    parameter int N_CRATES        = 4,
    parameter int SELF_BUSY_TICKS = DEFAULT_SELF_BUSY,
    parameter int CAL_W           = 16,
    parameter int CAL_DLY_RST     = 4,
    parameter int EVT_W           = 24,
    parameter int TIME_W          = 32,
    parameter int SYNC_LOG2       = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pass_i,
    input  logic [N_CRATES-1:0] crate_busy_i,
    input  logic                reg_wr_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [CAL_W-1:0]    reg_wdata_i,
    output logic                accept_o,
    output logic                cal_o,
    output logic                synch_o,
    output logic                busy_o,
    output logic [EVT_W-1:0]    evt_num_o,
    output logic [EVT_W-1:0]    pass_total_o,
    output logic [EVT_W-1:0]    suppressed_o,
    output logic [TIME_W-1:0]   evt_time_o
);

    reg_cmd_t    cmd;
    accept_req_t req;
    logic        self_busy;
    logic        ovf_busy;
    logic        cal_due;

    assign cmd    = decode_cmd(reg_wr_i, reg_addr_i);
    assign busy_o = (|crate_busy_i) | self_busy | ovf_busy;

    always_comb begin
        req.from_pass = pass_i;
        req.from_cal  = cal_due;
        req.grant     = !busy_o && (pass_i || cal_due);
    end

    trig_busy_unit #(
        .SELF_BUSY_TICKS(SELF_BUSY_TICKS)
    ) u_busy (
        .clk      (clk),
        .rst      (rst),
        .fire     (req.grant),
        .ro_ack   (cmd.ro_ack),
        .self_busy(self_busy),
        .ovf_busy (ovf_busy)
    );

    trig_cal_seq #(
        .CAL_W      (CAL_W),
        .CAL_DLY_RST(CAL_DLY_RST)
    ) u_cal (
        .clk      (clk),
        .rst      (rst),
        .go       (cmd.cal_go),
        .dly_wr   (cmd.cal_dly),
        .wdata    (reg_wdata_i),
        .grant    (req.grant),
        .cal_pulse(cal_o),
        .cal_due  (cal_due)
    );

    trig_event_book #(
        .EVT_W    (EVT_W),
        .TIME_W   (TIME_W),
        .SYNC_LOG2(SYNC_LOG2)
    ) u_book (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .accept    (accept_o),
        .synch     (synch_o),
        .evt_num   (evt_num_o),
        .pass_total(pass_total_o),
        .evt_time  (evt_time_o)
    );

    assign suppressed_o = pass_total_o - evt_num_o;

endmodule

// File: rtl/trig_accept_chk.sv
module trig_accept_chk #(
    parameter int SELF_BUSY_TICKS = 23810,
    parameter int SYNC_LOG2       = 8,
    parameter int EVT_W           = 24,
    localparam int GAP_W = $clog2(SELF_BUSY_TICKS + 2)
) (
    input logic             clk,
    input logic             rst,
    input logic             accept_o,
    input logic             synch_o,
    input logic             cal_o,
    input logic             busy_o,
    input logic             reg_wr_i,
    input logic [1:0]       reg_addr_i,
    input logic [EVT_W-1:0] evt_num_o,
    input logic [EVT_W-1:0] pass_total_o
);

    logic [GAP_W-1:0] gap;
    logic             seen;
    logic             pend;
    logic             ack_now;

    assign ack_now = reg_wr_i && (reg_addr_i == 2'd2);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (accept_o) begin
                gap  <= '0;
                seen <= 1'b1;
            end else if (gap != GAP_W'(SELF_BUSY_TICKS + 1)) begin
                gap <= gap + 1'b1;
            end
            if (ack_now) pend <= 1'b0;
            else if (accept_o) pend <= 1'b1;
        end
    end

    AST_ACCEPT_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> !$past(busy_o)); // R1
    AST_SELF_SPACING: assert property (@(posedge clk) disable iff (rst)
        (accept_o && seen) |-> (gap >= GAP_W'(SELF_BUSY_TICKS))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> !pend); // R4
    AST_CAL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cal_o |=> !cal_o); // R5
    AST_SYNCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        synch_o |-> (accept_o && (evt_num_o[SYNC_LOG2-1:0] == '0))); // R8
    AST_EVT_STEP: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> (evt_num_o == $past(evt_num_o) + 1'b1)); // R9
    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !accept_o |-> $stable(evt_num_o)); // R9
    AST_PASS_COVERS_EVT: assert property (@(posedge clk) disable iff (rst)
        pass_total_o >= evt_num_o); // R9

endmodule

bind trig_accept_ctrl trig_accept_chk #(
    .SELF_BUSY_TICKS(SELF_BUSY_TICKS),
    .SYNC_LOG2      (SYNC_LOG2),
    .EVT_W          (EVT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .accept_o    (accept_o),
    .synch_o     (synch_o),
    .cal_o       (cal_o),
    .busy_o      (busy_o),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .evt_num_o   (evt_num_o),
    .pass_total_o(pass_total_o)
);

// File: tb/tb_trig_accept_ctrl.sv
`timescale 1ns/1ps
module tb_trig_accept_ctrl;

    localparam int NC = 3;
    localparam int SB = 6;
    localparam int CW = 16;
    localparam int EW = 24;
    localparam int TW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pass_i = 1'b0;
    logic [NC-1:0] crate_busy_i = '0;
    logic          reg_wr_i = 1'b0;
    logic [1:0]    reg_addr_i = 2'd0;
    logic [CW-1:0] reg_wdata_i = '0;
    logic          accept_o, cal_o, synch_o, busy_o;
    logic [EW-1:0] evt_num_o, pass_total_o, suppressed_o;
    logic [TW-1:0] evt_time_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    longint exp_evt  = 0;
    longint exp_pass = 0;
    longint tb_ticks = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) tb_ticks <= 0;
        else     tb_ticks <= tb_ticks + 1;
    end

    trig_accept_ctrl #(
        .N_CRATES(NC), .SELF_BUSY_TICKS(SB), .CAL_W(CW), .CAL_DLY_RST(4),
        .EVT_W(EW), .TIME_W(TW), .SYNC_LOG2(8)
    ) dut (
        .clk(clk), .rst(rst), .pass_i(pass_i), .crate_busy_i(crate_busy_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .accept_o(accept_o), .cal_o(cal_o), .synch_o(synch_o), .busy_o(busy_o),
        .evt_num_o(evt_num_o), .pass_total_o(pass_total_o),
        .suppressed_o(suppressed_o), .evt_time_o(evt_time_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [CW-1:0] d);
        reg_addr_i  = a;
        reg_wdata_i = d;
        reg_wr_i    = 1'b1;
        tick();
        reg_wr_i    = 1'b0;
    endtask

    task automatic fire_pass();
        pass_i = 1'b1;
        tick();
        pass_i = 1'b0;
    endtask

    task automatic ready();
        reg_write(2'd2, '0);
        repeat (SB + 2) tick();
    endtask

    task automatic check_counts(input string req);
        check({req, " evt_num"}, evt_num_o, exp_evt);
        check({req, " pass_total"}, pass_total_o, exp_pass);
        check({req, " suppressed"}, suppressed_o, exp_pass - exp_evt);
    endtask

    task automatic cal_run(input int d);
        ready();
        reg_write(2'd1, CW'(d));
        reg_write(2'd0, '0);
        check("R5 cal pulse", cal_o, 1);
        for (int i = 1; i <= d + 2; i++) begin
            tick();
            check("R5 cal accept timing", accept_o, (i == d + 2) ? 1 : 0);
            if (i == 1) check("R5 cal pulse width", cal_o, 0);
        end
        exp_evt++;
        exp_pass++;
        check_counts("R5");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 reset accept", accept_o, 0);
        check("R1 reset cal", cal_o, 0);
        check("R1 reset synch", synch_o, 0);
        check("R1 reset busy", busy_o, 0);
        check_counts("R9 reset");

        // R1 R10 basic accept and time stamp
        fire_pass();
        check("R1 accept", accept_o, 1);
        check("R10 time stamp", evt_time_o, tb_ticks - 1);
        exp_evt++; exp_pass++;
        check_counts("R9");
        tick();
        check("R1 single pulse", accept_o, 0);
        check("R3 busy after accept", busy_o, 1);

        // R4 overflow holds until acknowledge
        repeat (SB + 2) tick();
        fire_pass();
        exp_pass++;
        check("R4 blocked before ack", accept_o, 0);
        reg_write(2'd2, '0);
        fire_pass();
        exp_pass++; exp_evt++;
        check("R4 accepted after ack", accept_o, 1);
        check("R10 time stamp 2", evt_time_o, tb_ticks - 1);
        check_counts("R4");

        // R3 sweep of pass distance after an accept
        for (int g = 1; g <= SB + 2; g++) begin
            ready();
            fire_pass();
            exp_pass++; exp_evt++;
            check("R3 lead accept", accept_o, 1);
            if (g >= 2) begin
                reg_write(2'd2, '0);
                repeat (g - 2) tick();
            end
            fire_pass();
            exp_pass++;
            if (g >= SB + 1) exp_evt++;
            check($sformatf("R3 gap %0d", g), accept_o, (g >= SB + 1) ? 1 : 0);
            check_counts("R3");
        end

        // R4 ack at the same edge as an accept keeps the flag set
        ready();
        reg_addr_i = 2'd2;
        reg_wr_i   = 1'b1;
        fire_pass();
        reg_wr_i   = 1'b0;
        exp_pass++; exp_evt++;
        check("R4 same-edge accept", accept_o, 1);
        repeat (SB + 2) tick();
        fire_pass();
        exp_pass++;
        check("R4 same-edge ack ignored", accept_o, 0);

        // R2 each crate busy line blocks
        for (int c = 0; c < NC; c++) begin
            ready();
            crate_busy_i[c] = 1'b1;
            tick();
            check($sformatf("R2 busy_o crate %0d", c), busy_o, 1);
            fire_pass();
            exp_pass++;
            check($sformatf("R2 blocked crate %0d", c), accept_o, 0);
            crate_busy_i = '0;
            fire_pass();
            exp_pass++; exp_evt++;
            check($sformatf("R2 released crate %0d", c), accept_o, 1);
        end
        check_counts("R2");

        // R5 calibration delays
        cal_run(0);
        cal_run(1);
        cal_run(3);

        // R6 calibration waits while busy
        ready();
        reg_write(2'd1, CW'(1));
        crate_busy_i[1] = 1'b1;
        reg_write(2'd0, '0);
        check("R6 cal pulse under busy", cal_o, 1);
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                tick();
                seen += accept_o;
            end
            check("R6 held while busy", seen, 0);
        end
        crate_busy_i = '0;
        tick();
        check("R6 issued after busy clears", accept_o, 1);
        exp_evt++; exp_pass++;
        check_counts("R6");

        // R6 second start while running is ignored
        ready();
        reg_write(2'd1, CW'(5));
        reg_write(2'd0, '0);
        check("R6 first pulse", cal_o, 1);
        reg_write(2'd0, '0);
        check("R6 restart ignored", cal_o, 0);
        for (int i = 2; i <= 7; i++) begin
            tick();
            check("R6 original timing kept", accept_o, (i == 7) ? 1 : 0);
        end
        exp_evt++; exp_pass++;
        ready();
        begin
            int extra = 0;
            for (int i = 0; i < 10; i++) begin
                tick();
                extra += accept_o + cal_o;
            end
            check("R6 no second sequence", extra, 0);
        end
        check_counts("R6 restart");

        // R7 calibration due and pass at the same edge
        ready();
        reg_write(2'd1, CW'(2));
        reg_write(2'd0, '0);
        repeat (3) tick();
        fire_pass();
        check("R7 single accept", accept_o, 1);
        exp_evt++; exp_pass++;
        check_counts("R7");
        repeat (SB + 2) begin
            tick();
            check("R7 no extra accept", accept_o, 0);
        end
        reg_write(2'd2, '0);
        repeat (4) tick();
        check_counts("R7 after");

        // R8 synch on every 256th accept
        while (exp_evt < 257) begin
            ready();
            fire_pass();
            exp_evt++; exp_pass++;
            check("R8 accept", accept_o, 1);
            check($sformatf("R8 synch at evt %0d", exp_evt), synch_o,
                  (exp_evt % 256 == 0) ? 1 : 0);
        end
        check_counts("R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule